// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block is the timing base of an I2C master. From one peripheral clock it builds an SCL waveform whose low and high phases are set on their own. Two count fields are packed into one divider word: the low-phase count sits in the lower half and the high-phase count in the upper half. Each phase is cut into eight equal sub-steps of (count + 1) clocks. The low phase therefore lasts 8 × (low + 1) cycles, the high phase lasts 8 × (high + 1) cycles, and one bit takes 8 × ((low + 1) + (high + 1)) cycles. With both fields at zero the bit takes 16 cycles, the fastest rate.

Besides the SCL level, the block gives the master three single-cycle registered strobes. The first marks the end of each sub-step, and the master uses it to place SDA changes, sampling points and START/STOP edges. The second marks the end of a low phase and the third the end of a high phase. A divider write is held in a pending copy. The counters switch to the new values only when a new low phase starts, or while the block is disabled, so a phase already running is never cut short. Deasserting the enable input returns the counters to zero and parks SCL high.

Top module: `scl_phase_timer`

## Requirements
- R1: After reset, `scl` is 1 and `tick`, `low_end` and `high_end` are 0.
- R2: Each low phase, during which `scl` is 0, lasts 8 × (L + 1) clock cycles, where L = `div_word[CNT_W-1:0]` of the active setting.
- R3: Each high phase between two low phases lasts 8 × (H + 1) clock cycles, where H = `div_word[2*CNT_W-1:CNT_W]` of the active setting.
- R4: Every phase produces exactly 8 single-cycle `tick` pulses, one at the end of each sub-step. The eighth pulse falls in the first cycle of the following phase.
- R5: `low_end` is a single-cycle pulse in the first cycle in which `scl` is 1 after a low phase, and it is 0 at all other times.
- R6: `high_end` is a single-cycle pulse in the first cycle in which `scl` is 0 after a high phase.
- R7: While `en` is 0, from the cycle after it drops, `scl` is 1 and all strobes are 0. After `en` rises, `scl` goes to 0 in the cycle after the first enabled clock edge, and the first low phase runs its full length.
- R8: A cycle with `div_wr` = 1 captures `div_word` as pending. Pending becomes active only at the start of a low phase or while `en` is 0. A low or high phase already in progress, and the high phase that follows a low phase in which the write happened, keep the old setting.
- R9: With L = 0 and H = 0 the SCL period is 16 cycles: 8 cycles low and 8 cycles high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; 0 holds the counters at zero and SCL high |
| div_wr | input | 1 | Divider write strobe |
| div_word | input | 2*CNT_W | Divider word: low count in the lower half, high count in the upper half |
| scl | output | 1 | SCL level (1 = released/high) |
| tick | output | 1 | Sub-step end pulse |
| low_end | output | 1 | End-of-low-phase pulse |
| high_end | output | 1 | End-of-high-phase pulse |

## Verification
The hardest case to reach from the ports is a divider write that lands inside a running phase. It must change neither that phase nor, for a write during a low phase, the high phase after it, and only the next low phase may pick it up. The stimulus measures phases edge to edge and raises `div_wr` at a chosen cycle offset inside a chosen phase. It then checks the lengths of the following three phases against the old and new fields. Random field pairs with a fixed seed, the all-zero setting and a mid-phase disable with re-enable complete the stimulus.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;
endpackage

// File: rtl/scl_div_shadow.sv
module scl_div_shadow #(
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [2*CNT_W-1:0] word,
   input  logic               load,
   output logic [CNT_W-1:0]   lo,
   output logic [CNT_W-1:0]   hi
);
   logic [2*CNT_W-1:0] pend_q;
   logic [2*CNT_W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (wr)   pend_q <= word;
         if (load) act_q  <= pend_q;
      end
   end

   assign lo = act_q[CNT_W-1:0];
   assign hi = act_q[2*CNT_W-1:CNT_W];

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_q)) else $error("active divider changed mid-phase"); // R8
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter
   import scl_timer_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int SUB_STEPS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] lim_lo,
   input  logic [CNT_W-1:0] lim_hi,
   output logic             bnd,
   output logic             lo_end_c,
   output logic             hi_end_c,
   output logic             scl_c,
   output logic             load_req
);
   localparam int STEP_W = $clog2(SUB_STEPS);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SUB_STEPS - 1);

   phase_e            phase_q, phase_n;
   logic [CNT_W-1:0]  sub_q, sub_n, lim;
   logic [STEP_W-1:0] step_q, step_n;
   logic              at_lim, last_step;

   always_comb begin
      lim       = (phase_q == PH_HIGH) ? lim_hi : lim_lo;
      at_lim    = (sub_q == lim);
      last_step = (step_q == LAST_STEP);
      phase_n   = phase_q;
      sub_n     = sub_q + 1'b1;
      step_n    = step_q;
      if (!en) begin
         phase_n = PH_IDLE;
         sub_n   = '0;
         step_n  = '0;
      end else if (phase_q == PH_IDLE) begin
         phase_n = PH_LOW;
         sub_n   = '0;
      end else if (at_lim) begin
         sub_n  = '0;
         step_n = step_q + 1'b1;
         if (last_step) phase_n = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sub_q   <= '0;
         step_q  <= '0;
      end else begin
         phase_q <= phase_n;
         sub_q   <= sub_n;
         step_q  <= step_n;
      end
   end

   assign bnd      = en && (phase_q != PH_IDLE) && at_lim;
   assign lo_end_c = bnd && last_step && (phase_q == PH_LOW);
   assign hi_end_c = bnd && last_step && (phase_q == PH_HIGH);
   assign load_req = !en || (phase_q == PH_IDLE) || hi_end_c;
   assign scl_c    = (phase_n != PH_LOW);

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase_q == PH_IDLE) && (sub_q == '0) && (step_q == '0)) else $error("counters not cleared"); // R7
   AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sub_q <= lim) else $error("sub-step counter past its limit"); // R2
   AST_NO_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !bnd) else $error("boundary while idle"); // R7
endmodule

// File: rtl/scl_strobe_stage.sv
module scl_strobe_stage #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bnd,
   input  logic lo_end_c,
   input  logic hi_end_c,
   input  logic scl_c,
   output logic scl,
   output logic tick,
   output logic low_end,
   output logic high_end
);
   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_c;
   end
   assign scl = scl_q;

   if (REG_OUT) begin : g_reg
      logic tick_q, lo_q, hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tick_q <= 1'b0;
            lo_q   <= 1'b0;
            hi_q   <= 1'b0;
         end else begin
            tick_q <= bnd;
            lo_q   <= lo_end_c;
            hi_q   <= hi_end_c;
         end
      end
      assign tick     = tick_q;
      assign low_end  = lo_q;
      assign high_end = hi_q;

      AST_LOW_END_RISE: assert property (@(posedge clk) disable iff (!rst_n)
         low_end |-> (scl && !$past(scl))) else $error("low_end not at SCL rise"); // R5
      AST_HIGH_END_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         high_end |-> (!scl && $past(scl))) else $error("high_end not at SCL fall"); // R6
      AST_LOW_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         low_end |=> !low_end) else $error("low_end wider than one cycle"); // R5
      AST_ENDS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(low_end && high_end)) else $error("both phase ends at once"); // R6
      AST_END_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         (low_end || high_end) |-> tick) else $error("phase end without tick"); // R4
   end else begin : g_comb
      assign tick     = bnd;
      assign low_end  = lo_end_c;
      assign high_end = hi_end_c;
   end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
   parameter int CNT_W     = 16,
   parameter int SUB_STEPS = 8,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               div_wr,
   input  logic [2*CNT_W-1:0] div_word,
   output logic               scl,
   output logic               tick,
   output logic               low_end,
   output logic               high_end
);
   if (CNT_W < 1 || 2 * CNT_W > 32) begin : g_bad_width
      $error("CNT_W must give a divider word of at most 32 bits");
   end
   if (SUB_STEPS < 2 || (SUB_STEPS & (SUB_STEPS - 1)) != 0) begin : g_bad_steps
      $error("SUB_STEPS must be a power of two, at least 2");
   end

   logic [CNT_W-1:0] act_lo, act_hi;
   logic             bnd, lo_end_c, hi_end_c, scl_c, load_req;

   scl_div_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (div_wr),
      .word (div_word),
      .load (load_req),
      .lo   (act_lo),
      .hi   (act_hi)
   );

   scl_phase_counter #(.CNT_W(CNT_W), .SUB_STEPS(SUB_STEPS)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .lim_lo  (act_lo),
      .lim_hi  (act_hi),
      .bnd     (bnd),
      .lo_end_c(lo_end_c),
      .hi_end_c(hi_end_c),
      .scl_c   (scl_c),
      .load_req(load_req)
   );

   scl_strobe_stage #(.REG_OUT(REG_OUT)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .bnd     (bnd),
      .lo_end_c(lo_end_c),
      .hi_end_c(hi_end_c),
      .scl_c   (scl_c),
      .scl     (scl),
      .tick    (tick),
      .low_end (low_end),
      .high_end(high_end)
   );

   AST_IDLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> scl) else $error("SCL not parked high when disabled"); // R7
endmodule

// File: tb/scl_phase_timer_bench.sv
`timescale 1ns/1ps
module scl_phase_timer_bench;
   localparam int CNT_W = 16;
   localparam int STEPS = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               en = 1'b0;
   logic               div_wr = 1'b0;
   logic [2*CNT_W-1:0] div_word = '0;
   logic               scl, tick, low_end, high_end;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   scl_phase_timer #(.CNT_W(CNT_W), .SUB_STEPS(STEPS)) u_scl_phase_timer (
      .clk(clk), .rst_n(rst_n), .en(en), .div_wr(div_wr), .div_word(div_word),
      .scl(scl), .tick(tick), .low_end(low_end), .high_end(high_end)
   );

   function automatic int phase_len(int f);
      return STEPS * (f + 1);
   endfunction

   task automatic chk(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Called at the negedge inside the first cycle of a phase at level lvl.
   // Returns at the negedge inside the first cycle of the next phase.
   task automatic measure(input bit lvl, input int wr_at, input logic [2*CNT_W-1:0] wr_val,
                          output int len, output int ticks, output bit end_seen);
      len = 1; ticks = 0; end_seen = 1'b0;
      while (len < 5000) begin
         div_wr   = (len == wr_at);
         div_word = (len == wr_at) ? wr_val : div_word;
         @(negedge clk);
         ticks += int'(tick);
         if (scl != lvl) begin
            end_seen = lvl ? (high_end && !low_end) : (low_end && !high_end);
            break;
         end
         if (low_end || high_end) ticks += 100;
         len++;
      end
      div_wr = 1'b0;
   endtask

   task automatic load_div(int lo, int hi);
      div_word = {CNT_W'(hi), CNT_W'(lo)};
      div_wr   = 1'b1;
      @(negedge clk);
      div_wr   = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic start_run();
      en = 1'b1;
      @(negedge clk);
      chk("R7 scl low after enable", int'(scl), 0);
   endtask

   task automatic check_pair(string tag, int lo, int hi);
      int len, tk; bit e;
      measure(1'b0, 0, '0, len, tk, e);
      chk({tag, " R2 low length"}, len, phase_len(lo));
      chk({tag, " R4 low ticks"}, tk, STEPS);
      chk({tag, " R5 low_end at rise"}, int'(e), 1);
      measure(1'b1, 0, '0, len, tk, e);
      chk({tag, " R3 high length"}, len, phase_len(hi));
      chk({tag, " R4 high ticks"}, tk, STEPS);
      chk({tag, " R6 high_end at fall"}, int'(e), 1);
   endtask

   task automatic stop_run();
      en = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         chk("R7 idle scl high", int'(scl), 1);
         chk("R7 idle strobes", int'(tick) + int'(low_end) + int'(high_end), 0);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin : main
      int len, tk, lo, hi;
      bit e;
      void'($urandom(32'h5C1_7A11));
      repeat (3) @(negedge clk);
      chk("R1 reset scl", int'(scl), 1);
      chk("R1 reset strobes", int'(tick) + int'(low_end) + int'(high_end), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 scl after release", int'(scl), 1);

      // R9: fastest setting, 8 low + 8 high
      load_div(0, 0);
      start_run();
      check_pair("R9 zero", 0, 0);
      check_pair("R9 zero again", 0, 0);
      stop_run();

      // asymmetric directed pair (field order, R2/R3)
      load_div(3, 9);
      start_run();
      check_pair("dir 3/9", 3, 9);
      // R7: disable mid low phase, then full-length restart
      repeat (5) @(negedge clk);
      stop_run();
      start_run();
      check_pair("R7 restart 3/9", 3, 9);
      stop_run();

      // R8: write during a high phase
      load_div(2, 5);
      start_run();
      measure(1'b0, 0, '0, len, tk, e);
      chk("R8a low before write", len, phase_len(2));
      measure(1'b1, 4, {CNT_W'(7), CNT_W'(1)}, len, tk, e);
      chk("R8a high keeps old H", len, phase_len(5));
      check_pair("R8a new setting", 1, 7);
      stop_run();

      // R8: write during a low phase; following high keeps old H
      load_div(4, 2);
      start_run();
      measure(1'b0, 6, {CNT_W'(0), CNT_W'(6)}, len, tk, e);
      chk("R8b low keeps old L", len, phase_len(4));
      measure(1'b1, 0, '0, len, tk, e);
      chk("R8b high keeps old H", len, phase_len(2));
      check_pair("R8b new setting", 6, 0);
      stop_run();

      // constrained random pairs
      for (int n = 0; n < 8; n++) begin
         lo = int'($urandom_range(15, 0));
         hi = int'($urandom_range(15, 0));
         load_div(lo, hi);
         start_run();
         check_pair("rand", lo, hi);
         check_pair("rand repeat", lo, hi);
         stop_run();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule